// File: doc/BRIEF.md
# Deferred Store Commit Stage for a Direct-Mapped Data Cache

This block sits between a load/store request stream and a direct-mapped, single-cycle data cache. A request names a byte address, an access size, store data and whether it is a load or a store. Loads read the tag and the data word in the cycle they are accepted, and the result comes out one cycle later. A store has its tag checked in the cycle it is accepted. If the check hits, the finished word is parked in a pending register and written into the data array during the next cycle. The extra stage gives an outside agent a cycle to cancel the write, through the kill input, before anything in the array changes.

The tag array has a path of its own, so the tag check of the next full-word store overlaps the array write of the previous store. Storage has one write enable per word of a line. A full-word store therefore never reads the old line. A byte or halfword store reads the old word at its tag check, merges its bytes into it, and commits the merged word. When the pending word is the one a following load or partial store touches, it is taken from the pending register instead of the array. A request that needs the single data port while a commit holds it waits one cycle. Tags are installed through a small install port that is driven by an outside refill engine.

The control is a two-state machine. In `IDLE` no store is pending. In `PEND` a checked store is waiting and commits during the current cycle unless kill is high. The transitions are:
- *capture* (`IDLE`→`PEND`): a store hits.
- *chain* (`PEND`→`PEND`): a store hits while a commit is in progress.
- *retire* (`PEND`→`IDLE`): the commit completes and no new store hits.
- *cancel* (`PEND`→`IDLE` with kill): the pending word is dropped.

Top module: `dstore_pipe`

## Requirements
- R1: After reset, `stall` and `rsp_valid` are 0, every tag is invalid so any load misses, and every data word reads as zero once its tag is installed.
- R2: A request is accepted in a cycle where `req_valid`=1 and `stall`=0. Exactly one cycle later `rsp_valid`=1. A load hit returns its bytes zero-extended in `rsp_rdata`, shifted down from their lane (byte lane = address bits [1:0]).
- R3: A store whose tag hits reports `rsp_hit`=1 and writes the array in the cycle after acceptance. Loads issued after that see the new data.
- R4: A request whose tag misses reports `rsp_hit`=0 and `rsp_rdata`=0. A missing store leaves the array unchanged and nothing pending. Address layout: bits [1:0] byte lane, [3:2] word in line, [7:4] set index, [15:8] tag.
- R5: When `kill_i` is high in the cycle a pending store would commit, the word is not written, it is not forwarded, and `store_dropped` is 1 in the following cycle.
- R6: A load that arrives during a commit and addresses the pending word is served from the pending register without stall.
- R7: A load that arrives during a commit and addresses any other word sees `stall`=1 for exactly one cycle and then reads the array.
- R8: A full-word store is never stalled. Its tag check overlaps the commit of the previous store.
- R9: A byte or halfword store changes only the selected byte lanes of its word and keeps the other lanes.
- R10: A partial store during a commit to the pending word merges against the pending data without stall. To any other word it stalls one cycle.
- R11: Size codes: 00 byte, 01 halfword (address bit 0 ignored), 10 word, 11 treated as word.
- R12: `kill_i` has no effect when no store is pending: `store_dropped` stays 0 and the array keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code (R11) |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| kill_i | input | 1 | Cancels the commit of the pending store this cycle |
| fill_valid | input | 1 | Install a tag |
| fill_index | input | IDX_W | Set to install |
| fill_tag | input | TAG_W | Tag to install |
| stall | output | 1 | Request not accepted this cycle |
| rsp_valid | output | 1 | Response for the request accepted last cycle |
| rsp_store | output | 1 | The response belongs to a store |
| rsp_hit | output | 1 | Tag check hit |
| rsp_rdata | output | 32 | Load data, zero-extended |
| store_dropped | output | 1 | A pending store was cancelled last cycle |

## Verification
The checker watches on every cycle that a stall only appears while a store is pending, lasts one cycle, and never hits a full-word store. It also checks that every accepted request gets its response the next cycle and no other cycle does, that misses return zero data, and that a drop report is always preceded by a kill during a pending store. Only the directed scenarios can show whether the data is right. That covers whether forwarded and merged words carry the correct bytes, whether a cancelled or missing store really leaves the array untouched, and whether later loads see each commit.

// File: rtl/dstore_pkg.sv
package dstore_pkg;

    parameter int DS_LANES  = 4;
    parameter int DS_LANE_W = $clog2(DS_LANES);
    parameter int DS_DW     = 8 * DS_LANES;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } acc_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } pipe_state_e;

endpackage

// File: rtl/ds_tag_store.sv
module ds_tag_store #(
    parameter int IDX_W = 4,
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic [IDX_W-1:0] look_idx,
    input  logic [TAG_W-1:0] look_tag,
    output logic             look_hit
);
    localparam int SETS = 1 << IDX_W;

    logic [TAG_W-1:0] tag_q [SETS];
    logic [SETS-1:0]  vld_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int s = 0; s < SETS; s++) tag_q[s] <= '0;
        end else if (fill_en) begin
            vld_q[fill_idx] <= 1'b1;
            tag_q[fill_idx] <= fill_tag;
        end
    end

    assign look_hit = vld_q[look_idx] && (tag_q[look_idx] == look_tag);

endmodule

// File: rtl/ds_line_store.sv
module ds_line_store #(
    parameter int IDX_W      = 4,
    parameter int LINE_WORDS = 4,
    parameter int DW         = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [IDX_W-1:0]              port_idx,
    input  logic [$clog2(LINE_WORDS)-1:0] port_word,
    input  logic                          wr_en,
    input  logic [DW-1:0]                 wr_data,
    output logic [DW-1:0]                 rd_data
);
    localparam int SETS  = 1 << IDX_W;
    localparam int OFF_W = $clog2(LINE_WORDS);

    logic [DW-1:0] col_rd [LINE_WORDS];

    // one column per word of the line, each with its own write enable
    for (genvar w = 0; w < LINE_WORDS; w++) begin : g_col
        logic [DW-1:0] col_q [SETS];
        logic          word_we;

        assign word_we = wr_en && (port_word == OFF_W'(w));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int s = 0; s < SETS; s++) col_q[s] <= '0;
            end else if (word_we) begin
                col_q[port_idx] <= wr_data;
            end
        end

        assign col_rd[w] = col_q[port_idx];
    end

    assign rd_data = col_rd[port_word];

endmodule

// File: rtl/ds_lane_unit.sv
module ds_lane_unit
    import dstore_pkg::*;
(
    input  acc_size_e              size,
    input  logic [DS_LANE_W-1:0]   off,
    input  logic [DS_DW-1:0]       old_word,
    input  logic [DS_DW-1:0]       new_data,
    output logic [DS_DW-1:0]       merged,
    output logic [DS_DW-1:0]       loaded
);
    logic [DS_LANES-1:0]  sel;
    logic [DS_DW-1:0]     rep;
    logic [DS_LANE_W-1:0] a_off;
    logic [DS_DW-1:0]     shifted;

    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                rep   = {DS_LANES{new_data[7:0]}};
                a_off = off;
            end
            SZ_HALF: begin
                rep   = {(DS_LANES/2){new_data[15:0]}};
                a_off = {off[DS_LANE_W-1:1], 1'b0};
            end
            default: begin
                rep   = new_data;
                a_off = '0;
            end
        endcase
    end

    for (genvar l = 0; l < DS_LANES; l++) begin : g_lane
        always_comb begin
            unique case (size)
                SZ_BYTE: sel[l] = (DS_LANE_W'(l) == off);
                SZ_HALF: sel[l] = (DS_LANE_W'(l) >> 1) == (off >> 1);
                default: sel[l] = 1'b1;
            endcase
        end
        assign merged[l*8 +: 8] = sel[l] ? rep[l*8 +: 8] : old_word[l*8 +: 8];
    end

    assign shifted = old_word >> {a_off, 3'b000};

    always_comb begin
        unique case (size)
            SZ_BYTE: loaded = {{(DS_DW-8){1'b0}},  shifted[7:0]};
            SZ_HALF: loaded = {{(DS_DW-16){1'b0}}, shifted[15:0]};
            default: loaded = shifted;
        endcase
    end

endmodule

// File: rtl/dstore_pipe.sv
module dstore_pipe
    import dstore_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int IDX_W      = 4,
    parameter int LINE_WORDS = 4,
    parameter int TAG_W      = ADDR_W - IDX_W - $clog2(LINE_WORDS) - DS_LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic              kill_i,
    input  logic              fill_valid,
    input  logic [IDX_W-1:0]  fill_index,
    input  logic [TAG_W-1:0]  fill_tag,
    output logic              stall,
    output logic              rsp_valid,
    output logic              rsp_store,
    output logic              rsp_hit,
    output logic [31:0]       rsp_rdata,
    output logic              store_dropped
);
    localparam int OFF_W  = $clog2(LINE_WORDS);
    localparam int WA_W   = ADDR_W - DS_LANE_W;
    localparam int IDX_LO = DS_LANE_W + OFF_W;

    // request fields
    logic [DS_LANE_W-1:0] req_off;
    logic [OFF_W-1:0]     req_word;
    logic [IDX_W-1:0]     req_idx;
    logic [TAG_W-1:0]     req_tag;
    logic [WA_W-1:0]      req_wa;
    acc_size_e            req_sz;

    assign req_off  = req_addr[DS_LANE_W-1:0];
    assign req_word = req_addr[DS_LANE_W +: OFF_W];
    assign req_idx  = req_addr[IDX_LO +: IDX_W];
    assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
    assign req_wa   = req_addr[ADDR_W-1:DS_LANE_W];
    assign req_sz   = acc_size_e'(req_size);

    // control state and pending store
    pipe_state_e     state_q, state_d;
    logic [WA_W-1:0] pend_wa_q;
    logic [DS_DW-1:0] pend_data_q;
    logic            pend_live;

    // internal nets
    logic             tag_hit;
    logic             commit;
    logic             same_word;
    logic             full_store;
    logic             take;
    logic             capture;
    logic [IDX_W-1:0] port_idx;
    logic [OFF_W-1:0] port_word;
    logic [DS_DW-1:0] arr_rd;
    logic [DS_DW-1:0] old_word;
    logic [DS_DW-1:0] merged;
    logic [DS_DW-1:0] loaded;

    assign pend_live = (state_q == ST_PEND);

    ds_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .fill_en  (fill_valid),
        .fill_idx (fill_index),
        .fill_tag (fill_tag),
        .look_idx (req_idx),
        .look_tag (req_tag),
        .look_hit (tag_hit)
    );

    ds_line_store #(.IDX_W(IDX_W), .LINE_WORDS(LINE_WORDS), .DW(DS_DW)) u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_idx  (port_idx),
        .port_word (port_word),
        .wr_en     (commit),
        .wr_data   (pend_data_q),
        .rd_data   (arr_rd)
    );

    ds_lane_unit u_lanes (
        .size     (req_sz),
        .off      (req_off),
        .old_word (old_word),
        .new_data (req_wdata),
        .merged   (merged),
        .loaded   (loaded)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: capture / chain / retire / cancel
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (capture) state_d = ST_PEND;
            ST_PEND: state_d = capture ? ST_PEND : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // per-state outputs: port ownership, stall, forwarding source
    always_comb begin
        full_store = req_store && req_sz[1];
        commit     = 1'b0;
        same_word  = 1'b0;
        port_idx   = req_idx;
        port_word  = req_word;
        unique case (state_q)
            ST_IDLE: begin
                commit = 1'b0;
            end
            ST_PEND: begin
                commit    = !kill_i;
                same_word = (pend_wa_q == req_wa);
                if (commit) begin
                    port_idx  = pend_wa_q[OFF_W +: IDX_W];
                    port_word = pend_wa_q[OFF_W-1:0];
                end
            end
            default: commit = 1'b0;
        endcase
        stall    = req_valid && commit && !same_word && !full_store;
        take     = req_valid && !stall;
        capture  = take && req_store && tag_hit;
        old_word = (commit && same_word) ? pend_data_q : arr_rd;
    end

    // pending store register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_wa_q   <= '0;
            pend_data_q <= '0;
        end else if (capture) begin
            pend_wa_q   <= req_wa;
            pend_data_q <= merged;
        end
    end

    // response register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_store     <= 1'b0;
            rsp_hit       <= 1'b0;
            rsp_rdata     <= '0;
            store_dropped <= 1'b0;
        end else begin
            rsp_valid     <= take;
            rsp_store     <= take && req_store;
            rsp_hit       <= take && tag_hit;
            rsp_rdata     <= (take && !req_store && tag_hit) ? loaded : '0;
            store_dropped <= pend_live && kill_i;
        end
    end

endmodule

// File: rtl/ds_pipe_checker.sv
module ds_pipe_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_store,
    input logic [1:0]  req_size,
    input logic        kill_i,
    input logic        stall,
    input logic        rsp_valid,
    input logic        rsp_hit,
    input logic [31:0] rsp_rdata,
    input logic        store_dropped,
    input logic        pend_live
);
    AST_STALL_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> pend_live);                                              // R7
    AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);                                                 // R7
    AST_WORD_STORE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && req_size[1]) |-> !stall);               // R8
    AST_RSP_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !stall) |=> rsp_valid);                              // R2
    AST_RSP_ONLY_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !stall) |=> !rsp_valid);                            // R2
    AST_MISS_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_rdata == 32'h0));                 // R4
    AST_DROP_NEEDS_KILL: assert property (@(posedge clk) disable iff (!rst_n)
        store_dropped |-> ($past(kill_i) && $past(pend_live)));            // R5
    AST_KILL_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_i && !pend_live) |=> !store_dropped);                        // R12
endmodule

bind dstore_pipe ds_pipe_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_store     (req_store),
    .req_size      (req_size),
    .kill_i        (kill_i),
    .stall         (stall),
    .rsp_valid     (rsp_valid),
    .rsp_hit       (rsp_hit),
    .rsp_rdata     (rsp_rdata),
    .store_dropped (store_dropped),
    .pend_live     (pend_live)
);

// File: tb/dstore_pipe_test.sv
module dstore_pipe_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_store = 1'b0;
    logic [1:0]  req_size = 2'b10;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        kill_i = 1'b0;
    logic        fill_valid = 1'b0;
    logic [3:0]  fill_index = '0;
    logic [7:0]  fill_tag = '0;
    logic        stall;
    logic        rsp_valid;
    logic        rsp_store;
    logic        rsp_hit;
    logic [31:0] rsp_rdata;
    logic        store_dropped;

    int n_tests = 0;
    int n_fail  = 0;
    int stalls;
    logic        r_valid, r_store, r_hit, r_drop;
    logic [31:0] r_data;

    always #(PERIOD/2) clk = ~clk;

    dstore_pipe uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .kill_i(kill_i), .fill_valid(fill_valid), .fill_index(fill_index),
        .fill_tag(fill_tag), .stall(stall), .rsp_valid(rsp_valid),
        .rsp_store(rsp_store), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
        .store_dropped(store_dropped)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic capture_rsp();
        r_valid = rsp_valid;
        r_store = rsp_store;
        r_hit   = rsp_hit;
        r_data  = rsp_rdata;
        r_drop  = store_dropped;
    endtask

    // starts and ends at a falling edge
    task automatic issue(input logic st, input logic [1:0] sz, input logic [15:0] a,
                         input logic [31:0] d, input logic kl);
        req_valid = 1'b1; req_store = st; req_size = sz; req_addr = a;
        req_wdata = d; kill_i = kl;
        stalls = 0;
        #1;
        while (stall) begin
            stalls++;
            @(negedge clk);
            kill_i = 1'b0;
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        capture_rsp();
        req_valid = 1'b0;
        kill_i = 1'b0;
    endtask

    task automatic idle(input logic kl);
        req_valid = 1'b0; kill_i = kl;
        @(posedge clk);
        @(negedge clk);
        capture_rsp();
        kill_i = 1'b0;
    endtask

    task automatic fill(input logic [3:0] idx, input logic [7:0] tg);
        fill_valid = 1'b1; fill_index = idx; fill_tag = tg;
        @(posedge clk);
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic load_expect(input string req, input logic [1:0] sz, input logic [15:0] a,
                               input logic exp_hit, input logic [31:0] exp);
        issue(1'b0, sz, a, 32'h0, 1'b0);
        check({req, " hit"}, {31'h0, r_hit}, {31'h0, exp_hit});
        check({req, " data"}, r_data, exp);
    endtask

    task automatic t_reset();
        check("R1 stall after reset", {31'h0, stall}, 32'h0);
        check("R1 rsp_valid after reset", {31'h0, rsp_valid}, 32'h0);
        load_expect("R1 load before tag install", 2'b10, 16'h1210, 1'b0, 32'h0);
        fill(4'h1, 8'h12);
        load_expect("R1 fresh line reads zero", 2'b10, 16'h1210, 1'b1, 32'h0);
    endtask

    task automatic t_store_load();
        issue(1'b1, 2'b10, 16'h1214, 32'hA1B2C3D4, 1'b0);
        check("R3 store response", {30'h0, r_store, r_hit}, 32'h3);
        check("R2 store response valid", {31'h0, r_valid}, 32'h1);
        idle(1'b0);
        load_expect("R3 load after commit", 2'b10, 16'h1214, 1'b1, 32'hA1B2C3D4);
        load_expect("R2 byte lane 1", 2'b00, 16'h1215, 1'b1, 32'h000000C3);
        load_expect("R11 half upper", 2'b01, 16'h1216, 1'b1, 32'h0000A1B2);
        load_expect("R11 half bit0 ignored", 2'b01, 16'h1217, 1'b1, 32'h0000A1B2);
    endtask

    task automatic t_miss();
        issue(1'b1, 2'b10, 16'h3318, 32'hBADBAD00, 1'b0);
        check("R4 store miss", {31'h0, r_hit}, 32'h0);
        idle(1'b0);
        check("R4 no drop after miss", {31'h0, r_drop}, 32'h0);
        load_expect("R4 array unchanged", 2'b10, 16'h1218, 1'b1, 32'h0);
        load_expect("R4 load miss", 2'b10, 16'h3318, 1'b0, 32'h0);
    endtask

    task automatic t_kill();
        issue(1'b1, 2'b10, 16'h121C, 32'h55667788, 1'b0);
        idle(1'b1);
        check("R5 drop reported", {31'h0, r_drop}, 32'h1);
        load_expect("R5 cancelled word unchanged", 2'b10, 16'h121C, 1'b1, 32'h0);
        idle(1'b1);
        check("R12 kill without pending", {31'h0, r_drop}, 32'h0);
        load_expect("R12 array kept", 2'b10, 16'h1214, 1'b1, 32'hA1B2C3D4);
    endtask

    task automatic t_forward();
        issue(1'b1, 2'b10, 16'h1218, 32'h11223344, 1'b0);
        issue(1'b0, 2'b10, 16'h1218, 32'h0, 1'b0);
        check("R6 forward no stall", stalls, 0);
        check("R6 forwarded data", r_data, 32'h11223344);
    endtask

    task automatic t_stall_load();
        issue(1'b1, 2'b10, 16'h1210, 32'hDEADBEEF, 1'b0);
        issue(1'b0, 2'b10, 16'h1214, 32'h0, 1'b0);
        check("R7 one stall cycle", stalls, 1);
        check("R7 data after stall", r_data, 32'hA1B2C3D4);
        load_expect("R3 committed during stall", 2'b10, 16'h1210, 1'b1, 32'hDEADBEEF);
    endtask

    task automatic t_chain();
        issue(1'b1, 2'b10, 16'h1214, 32'h01020304, 1'b0);
        issue(1'b1, 2'b10, 16'h1218, 32'h0A0B0C0D, 1'b0);
        check("R8 chained store no stall", stalls, 0);
        idle(1'b0);
        load_expect("R8 first chained word", 2'b10, 16'h1214, 1'b1, 32'h01020304);
        load_expect("R8 second chained word", 2'b10, 16'h1218, 1'b1, 32'h0A0B0C0D);
    endtask

    task automatic t_kill_forward();
        issue(1'b1, 2'b10, 16'h1218, 32'hFFFFFFFF, 1'b0);
        issue(1'b0, 2'b10, 16'h1218, 32'h0, 1'b1);
        check("R5 no stall under kill", stalls, 0);
        check("R5 killed word not forwarded", r_data, 32'h0A0B0C0D);
        check("R5 drop with load", {31'h0, r_drop}, 32'h1);
    endtask

    task automatic t_partial();
        issue(1'b1, 2'b00, 16'h1211, 32'h00000077, 1'b0);
        idle(1'b0);
        load_expect("R9 byte merge", 2'b10, 16'h1210, 1'b1, 32'hDEAD77EF);
        issue(1'b1, 2'b01, 16'h1212, 32'h00001234, 1'b0);
        idle(1'b0);
        load_expect("R9 half merge", 2'b10, 16'h1210, 1'b1, 32'h123477EF);
    endtask

    task automatic t_partial_pending();
        issue(1'b1, 2'b10, 16'h121C, 32'hCAFEF00D, 1'b0);
        issue(1'b1, 2'b00, 16'h121F, 32'h00000099, 1'b0);
        check("R10 partial on pending no stall", stalls, 0);
        idle(1'b0);
        load_expect("R10 merged with pending", 2'b10, 16'h121C, 1'b1, 32'h99FEF00D);
        issue(1'b1, 2'b10, 16'h121C, 32'h00000000, 1'b0);
        issue(1'b1, 2'b01, 16'h1210, 32'h0000AAAA, 1'b0);
        check("R10 partial other word stalls", stalls, 1);
        idle(1'b0);
        load_expect("R10 other word merged", 2'b10, 16'h1210, 1'b1, 32'h1234AAAA);
        load_expect("R10 earlier commit kept", 2'b10, 16'h121C, 1'b1, 32'h0);
    endtask

    task automatic t_wide_code();
        issue(1'b1, 2'b11, 16'h1214, 32'h87654321, 1'b0);
        idle(1'b0);
        load_expect("R11 code 11 is word", 2'b10, 16'h1214, 1'b1, 32'h87654321);
    endtask

    initial begin
        #(PERIOD * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_store_load();
        t_miss();
        t_kill();
        t_forward();
        t_stall_load();
        t_chain();
        t_kill_forward();
        t_partial();
        t_partial_pending();
        t_wide_code();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule